// File: doc/BRIEF.md
# Carry-Save Radix-2 Montgomery Multiplier

This block multiplies two residues modulo an odd modulus and returns the Montgomery product R ≡ A·B·2^-(K+2) (mod N), with K the operand width. A single-cycle `start` pulse captures A, B and N in plain binary. The block raises `busy`, runs its internal sequence and then pulses `done` for one cycle with the binary product on `res`. No carry-save form ever appears at the ports.

All arithmetic passes through one carry-save adder level, so no carry ripples across the word in any cycle. The same adder serves three phases. First it folds the pair (B, N) into the binary sum B+N. Next it runs K+2 reduction iterations, each adding 0, N, B or B+N and then halving. Last it folds the redundant sum/carry pair back into binary. In the two folding phases the cells act either as one full adder per cycle or as two chained half adders per cycle (`FOLD_PAIR`). The pair setting halves the number of folding cycles. A zero detector on the carry vector ends each folding phase as soon as the carry is empty (`SKIP_EN`), so folds that would change nothing are never run. The zero test works on register outputs and adds no depth to the adder path.

Top module: `csmont_mul`

## Requirements
- R1: When `done` is high, `res` is congruent to A·B·2^-(K+2) modulo N. A, B and N are the values captured at the accepted `start`, and `res` is in unsigned binary.
- R2: When `done` is high, `res` is less than 2·N, so no final subtraction is applied.
- R3: A `start` seen while `busy` is low captures `a_in`, `b_in` and `n_in`. `busy` is high in the following cycle.
- R4: A `start` seen while `busy` is high is ignored, and the running operation completes with its original operands.
- R5: `done` is high for exactly one cycle and `busy` is low in that cycle. `res` holds its value until the next `done`.
- R6: Each reduction step adds one value to the redundant pair through one carry-save level, and the new sum is even before halving. The quotient bit is the parity of sum XOR carry XOR (A_i AND B_0). The added value is 0 for (A_i,q)=(0,0), N for (0,1), B for (1,0) and B+N for (1,1).
- R7: Before the loop, the adder folds B and N into B+N. Every folding pass, both before and after the loop, leaves the sum of the sum and carry vectors unchanged.
- R8: With `FOLD_PAIR`=1 each folding cycle does two half-adder passes. Latency is then never longer than with `FOLD_PAIR`=0, and results are identical.
- R9: With `SKIP_EN`=1 a folding phase ends in the first cycle the carry vector is zero. Latency never exceeds that of `SKIP_EN`=0, and results are identical.
- R10: With `SKIP_EN`=0 the latency from `start` to `done` is the same for every operand set.
- R11: After synchronous reset `busy`, `done` and `res` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| a_in | input | K | Multiplier A, binary, below N |
| b_in | input | K | Multiplicand B, binary, below N |
| n_in | input | K | Odd modulus N |
| busy | output | 1 | High from the cycle after an accepted start through the last folding cycle |
| done | output | 1 | One-cycle pulse when `res` is valid |
| res | output | K+1 | Montgomery product, binary, below 2·N |

## Verification
The assertions assume an odd N with A and B both below N. Under that assumption the redundant value stays below 4·N, the width of K+2 bits never overflows, and the result stays under 2·N. The stimulus only draws moduli that are forced odd and reduces each A and B modulo N before applying them. The corner values used are 0, N-1, N=1 and the largest odd K-bit modulus. Three instances run side by side (pair plus skip, full-adder plus skip, pair without skip), so the skip and pair settings can be compared on the same operands.

// File: rtl/csmont_pkg.sv
package csmont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOOP = 2'd2,
    ST_CONV = 2'd3
  } csmont_st_e;

  function automatic int fold_cycles(input int width, input bit pair);
    return pair ? (width + 1) / 2 : width;
  endfunction

  function automatic int max2(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/csmont_csa.sv
module csmont_csa #(
  parameter int W = 18
) (
  input  logic         pair_mode,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] fa_s, fa_maj, h1_s, h1_and, h2_and;
  logic [W-1:0] h1_c, h2_s;

  // per-bit cells: full adder, or two chained half adders
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fa_s[i]   = x[i] ^ y[i] ^ z[i];
    assign fa_maj[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    assign h1_s[i]   = x[i] ^ y[i];
    assign h1_and[i] = x[i] & y[i];
    assign h2_s[i]   = h1_s[i] ^ h1_c[i];
    assign h2_and[i] = h1_s[i] & h1_c[i];
  end

  assign h1_c = {h1_and[W-2:0], 1'b0};

  always_comb begin
    if (pair_mode) begin
      sum   = h2_s;
      carry = {h2_and[W-2:0], 1'b0};
    end else begin
      sum   = fa_s;
      carry = {fa_maj[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/csmont_zdet.sv
module csmont_zdet #(
  parameter int W   = 18,
  parameter int GRP = 4
) (
  input  logic [W-1:0] vec,
  output logic         zero
);
  localparam int NG = (W + GRP - 1) / GRP;
  localparam int WP = NG * GRP;

  logic [WP-1:0] padded;
  logic [NG-1:0] grp_any;

  assign padded = WP'(vec);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GRP +: GRP];
  end

  assign zero = ~|grp_any;
endmodule

// File: rtl/csmont_ctrl.sv
module csmont_ctrl
  import csmont_pkg::*;
#(
  parameter int K        = 16,
  parameter int PASS_CYC = 9,
  parameter bit SKIP_EN  = 1'b1,
  parameter int CW       = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       c_zero,
  output csmont_st_e st,
  output logic       busy,
  output logic       pre_exit,
  output logic       loop_last,
  output logic       conv_exit
);
  logic [CW-1:0] cnt_q;
  logic          pass_end;

  always_comb begin
    pass_end  = SKIP_EN ? c_zero : (cnt_q == CW'(PASS_CYC));
    pre_exit  = (st == ST_PRE) && pass_end;
    conv_exit = (st == ST_CONV) && pass_end;
    loop_last = (st == ST_LOOP) && (cnt_q == CW'(K + 1));
    busy      = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) st <= ST_PRE;
        end
        ST_PRE: begin
          if (pre_exit) begin
            st    <= ST_LOOP;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LOOP: begin
          if (loop_last) begin
            st    <= ST_CONV;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (conv_exit) begin
            st    <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/csmont_mul.sv
module csmont_mul
  import csmont_pkg::*;
#(
  parameter int K         = 16,
  parameter bit FOLD_PAIR = 1'b1,
  parameter bit SKIP_EN   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] b_in,
  input  logic [K-1:0] n_in,
  output logic         busy,
  output logic         done,
  output logic [K:0]   res
);
  localparam int W        = K + 2;
  localparam int PASS_CYC = fold_cycles(W, FOLD_PAIR);
  localparam int MAXC     = max2(K + 1, PASS_CYC);
  localparam int CW       = $clog2(MAXC + 1);

  csmont_st_e   st;
  logic         pre_exit, loop_last, conv_exit, c_zero;
  logic [W-1:0] a_q, b_q, n_q, bn_q, s_q, c_q;
  logic [W-1:0] addend, csa_z, csa_s, csa_c;
  logic         csa_pair, q_bit, a_bit;
  logic [K:0]   res_q;
  logic         done_q;

  csmont_ctrl #(
    .K(K), .PASS_CYC(PASS_CYC), .SKIP_EN(SKIP_EN), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .c_zero(c_zero),
    .st(st), .busy(busy), .pre_exit(pre_exit),
    .loop_last(loop_last), .conv_exit(conv_exit)
  );

  csmont_zdet #(.W(W)) u_zdet (.vec(c_q), .zero(c_zero));

  // quotient bit and addend choice for one reduction step
  always_comb begin
    a_bit = a_q[0];
    q_bit = s_q[0] ^ c_q[0] ^ (a_bit & b_q[0]);
    case ({a_bit, q_bit})
      2'b00:   addend = '0;
      2'b01:   addend = n_q;
      2'b10:   addend = b_q;
      default: addend = bn_q;
    endcase
    csa_z    = (st == ST_LOOP) ? addend : '0;
    csa_pair = (st == ST_LOOP) ? 1'b0 : FOLD_PAIR;
  end

  csmont_csa #(.W(W)) u_csa (
    .pair_mode(csa_pair), .x(s_q), .y(c_q), .z(csa_z),
    .sum(csa_s), .carry(csa_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      n_q    <= '0;
      bn_q   <= '0;
      s_q    <= '0;
      c_q    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            a_q <= W'(a_in);
            b_q <= W'(b_in);
            n_q <= W'(n_in);
            s_q <= W'(b_in);
            c_q <= W'(n_in);
          end
        end
        ST_PRE: begin
          if (pre_exit) begin
            bn_q <= s_q;
            s_q  <= '0;
            c_q  <= '0;
          end else begin
            s_q <= csa_s;
            c_q <= csa_c;
          end
        end
        ST_LOOP: begin
          s_q <= csa_s >> 1;
          c_q <= csa_c >> 1;
          a_q <= a_q >> 1;
        end
        default: begin
          if (conv_exit) begin
            res_q  <= s_q[K:0];
            done_q <= 1'b1;
          end else begin
            s_q <= csa_s;
            c_q <= csa_c;
          end
        end
      endcase
    end
  end

  assign done = done_q;
  assign res  = res_q;
endmodule

// File: rtl/csmont_mul_chk.sv
module csmont_mul_chk #(
  parameter int K = 16,
  parameter int W = K + 2
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [K:0]   res,
  input logic [1:0]   st,
  input logic [W-1:0] n_q,
  input logic [W-1:0] s_q,
  input logic [W-1:0] c_q,
  input logic [W-1:0] csa_s
);
  logic [W:0] pair_val;
  assign pair_val = {1'b0, s_q} + {1'b0, c_q};

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R4
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(n_q));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  res_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ({1'b0, res} < {n_q, 1'b0}));

  // R6
  loop_even_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd2) |-> (csa_s[0] == 1'b0));

  // R7
  pre_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && $past(st) == 2'd1) |-> (pair_val == $past(pair_val)));

  // R7
  conv_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd3 && $past(st) == 2'd3) |-> (pair_val == $past(pair_val)));
endmodule

bind csmont_mul csmont_mul_chk #(.K(K), .W(K + 2)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .res(res), .st(st), .n_q(n_q), .s_q(s_q), .c_q(c_q), .csa_s(csa_s)
);

// File: tb/csmont_mul_tb.sv
module csmont_mul_tb;
  localparam int K       = 16;
  localparam int CLK_PER = 10;
  localparam int ND      = 3;

  typedef struct {
    longint unsigned a;
    longint unsigned b;
    longint unsigned n;
    longint unsigned e;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [K-1:0] a_in = '0, b_in = '0, n_in = '0;
  logic         busy_v [ND];
  logic         done_v [ND];
  logic [K:0]   res_v  [ND];

  int      n_run = 0, n_fail = 0;
  int      cyc = 0, st_cyc = 0;
  bit      fin [ND];
  bit      prev_done [ND];
  int      lat [ND];
  int      tot [ND];
  int      fixed_lat = -1;
  item_t   exp_q[$];
  item_t   cur;
  logic [K:0] seen_res [ND];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // instance 0: paired folding with skip; 1: full-adder folding with skip; 2: paired without skip
  csmont_mul #(.K(K), .FOLD_PAIR(1'b1), .SKIP_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in), .n_in(n_in),
    .busy(busy_v[0]), .done(done_v[0]), .res(res_v[0]));
  csmont_mul #(.K(K), .FOLD_PAIR(1'b0), .SKIP_EN(1'b1)) u_fa (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in), .n_in(n_in),
    .busy(busy_v[1]), .done(done_v[1]), .res(res_v[1]));
  csmont_mul #(.K(K), .FOLD_PAIR(1'b1), .SKIP_EN(1'b0)) u_noskip (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in), .n_in(n_in),
    .busy(busy_v[2]), .done(done_v[2]), .res(res_v[2]));

  function automatic longint unsigned ref_mm(longint unsigned a, longint unsigned b,
                                             longint unsigned n);
    longint unsigned r = (a * b) % n;
    for (int i = 0; i < K + 2; i++) begin
      if (r[0]) r = r + n;
      r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compares each result as it appears
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < ND; i++) begin
        if (prev_done[i]) check(!done_v[i], "R5 pulse width", done_v[i], 0);
        if (done_v[i] && !fin[i]) begin
          fin[i] = 1'b1;
          lat[i] = cyc - st_cyc;
          seen_res[i] = res_v[i];
          if (i == 0) begin
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else check(1'b0, "R1 queue", 0, 1);
          end
          check(!busy_v[i], "R5 busy low at done", busy_v[i], 0);
          check((longint'(res_v[i]) % cur.n) == cur.e, "R1 residue",
                longint'(res_v[i]) % cur.n, cur.e);
          check(longint'(res_v[i]) < 2 * cur.n, "R2 bound", res_v[i], 2 * cur.n);
        end
        prev_done[i] = done_v[i];
      end
    end
  end

  task automatic run_op(input longint unsigned a, input longint unsigned b,
                        input longint unsigned n, input bit poke);
    item_t it;
    int    t;
    it.a = a; it.b = b; it.n = n; it.e = ref_mm(a, b, n);
    exp_q.push_back(it);
    for (int i = 0; i < ND; i++) fin[i] = 1'b0;
    @(negedge clk);
    // R5: previous result still held before the next start
    for (int i = 0; i < ND; i++)
      if (tot[i] > 0) check(res_v[i] == seen_res[i], "R5 hold", res_v[i], seen_res[i]);
    a_in = K'(a); b_in = K'(b); n_in = K'(n);
    start = 1'b1;
    st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy_v[0] == 1'b1, "R3 busy after start", busy_v[0], 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      a_in = K'(n - 1); b_in = K'(n - 1); n_in = 16'hFFFF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy_v[0] == 1'b1, "R4 still busy", busy_v[0], 1);
    end
    t = 0;
    while (!(fin[0] && fin[1] && fin[2]) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 2000) check(1'b0, "watchdog", t, 0);
    check(res_v[0] == res_v[1] && res_v[0] == res_v[2], "R8 R9 same result",
          res_v[1], res_v[0]);
    check(lat[0] <= lat[1], "R8 paired latency", lat[0], lat[1]);
    check(lat[0] <= lat[2], "R9 skip latency", lat[0], lat[2]);
    if (fixed_lat < 0) fixed_lat = lat[2];
    check(lat[2] == fixed_lat, "R10 fixed latency", lat[2], fixed_lat);
    for (int i = 0; i < ND; i++) tot[i] += lat[i];
  endtask

  initial begin
    longint unsigned x, nn;
    for (int i = 0; i < ND; i++) begin
      tot[i] = 0; prev_done[i] = 1'b0; fin[i] = 1'b0; seen_res[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < ND; i++)
      check(!busy_v[i] && !done_v[i] && res_v[i] == '0, "R11 reset", res_v[i], 0);
    run_op(0, 5, 13, 1'b0);
    run_op(7, 0, 13, 1'b0);
    run_op(12, 12, 13, 1'b0);
    run_op(3, 5, 7, 1'b1);           // R4 start during run
    run_op(0, 0, 1, 1'b0);
    run_op(1, 1, 65535, 1'b0);
    run_op(65534, 65534, 65535, 1'b0);
    run_op(40000, 59999, 60001, 1'b1);
    run_op(32768, 32767, 32769, 1'b0);
    x = 64'd12345;
    for (int k = 0; k < 24; k++) begin
      x  = (x * 64'd6364136223846793005 + 64'd1442695040888963407);
      nn = ((x >> 33) & 64'hFFFF) | 64'd3;
      run_op((x >> 7) % nn, (x >> 19) % nn, nn, 1'b0);
    end
    check(tot[0] < tot[2], "R9 skip saves cycles", tot[0], tot[2]);
    check(tot[0] < tot[1], "R8 paired saves cycles", tot[0], tot[1]);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule